// File: doc/BRIEF.md
# Receive Character Queue with Fill Trigger and Idle Timeout

This block sits between a serial receiver and a host-side status and interrupt unit. The receiver hands it each assembled character together with three error flags (parity, framing, line break). The block stores them in arrival order until the host takes them, and reports status derived from the fill level. Those reports are: whether any character is waiting, a one-cycle overrun indication when a character arrives with no room for it, and a data-available condition at a programmable fill threshold. It also reports a character-idle timeout measured in 16x baud ticks, and an active-low receive-ready pin that works in either of two modes.

The write side is a valid-only stream with no back-pressure: a serial line cannot be paused, so a character offered while the store is full is dropped and reported as overrun. The read side is valid/ready: `out_valid` is high whenever a character is stored, `out_data`/flags show the oldest one, and a character is removed on each rising clock edge where both `out_valid` and `out_ready` are high. A pop and a push in the same cycle are both honoured, even when the store is full. Configuration pins are plain levels driven from the host's control registers. Short characters are right-justified on entry.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the store is empty: `out_valid`, `data_ready`, `data_avail`, `char_timeout` and `ovr_pulse` are 0 and `rxrdy_n` is 1.
- R2: Characters and their three flags leave through the read port in the order they arrived; `data_ready` is 1 exactly while at least one character is stored.
- R3: `cfg_len` codes 00, 01, 10, 11 mean 5, 6, 7, 8 data bits; bits above the character length are stored as 0.
- R4: With `cfg_fifo_en`=1 the store holds DEPTH (16) characters; with 0 it holds one. Any change of `cfg_fifo_en` empties the store.
- R5: A character offered while the store is full and no pop happens in that cycle is discarded, the stored contents are unchanged, and `ovr_pulse` is 1 for the one cycle after that edge.
- R6: `cfg_trig` codes 00, 01, 10, 11 select thresholds 1, 4, 8, 14; with the FIFO enabled `data_avail` is 1 while the fill level is at or above the threshold, and with it disabled while a character is stored.
- R7: With the FIFO enabled and at least one character stored, `char_timeout` rises once 768 `tick16` pulses (four 12-bit character times) have been counted since the last push or pop; any push or pop restarts the count and clears it.
- R8: With `cfg_rdy_mode`=0, `rxrdy_n` is 0 while at least one character is stored and 1 when empty.
- R9: With `cfg_rdy_mode`=1, `rxrdy_n` goes to 0 when `data_avail` or `char_timeout` is 1 and stays 0 until the store becomes empty.
- R10: A `rx_flush` pulse empties the store; a character offered in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| cfg_fifo_en | input | 1 | 1: multi-entry store; 0: single holding entry |
| cfg_trig | input | 2 | Fill threshold select |
| cfg_rdy_mode | input | 1 | Receive-ready pin mode |
| cfg_len | input | 2 | Character length code |
| rx_flush | input | 1 | Empty the store (pulse) |
| in_valid | input | 1 | A received character is offered this cycle |
| in_data | input | 8 | Received character bits, LSB first bit received |
| in_perr | input | 1 | Parity error flag of the offered character |
| in_ferr | input | 1 | Framing error flag of the offered character |
| in_brk | input | 1 | Line break flag of the offered character |
| out_ready | input | 1 | Host takes the oldest character |
| out_valid | output | 1 | A character is available to read |
| out_data | output | 8 | Oldest stored character |
| out_perr | output | 1 | Parity flag of the oldest character |
| out_ferr | output | 1 | Framing flag of the oldest character |
| out_brk | output | 1 | Break flag of the oldest character |
| data_ready | output | 1 | Status: store not empty |
| ovr_pulse | output | 1 | One-cycle overrun indication |
| data_avail | output | 1 | Fill level at or above threshold |
| char_timeout | output | 1 | Character idle timeout |
| rxrdy_n | output | 1 | Active-low receive-ready pin |

## Verification
The store is driven with short bursts carrying distinct flag combinations, which separate an ordering fault from a flag-routing fault, and with each length code on an all-ones byte, which exposes a wrong mask width. Threshold checks step the fill level across each of 4, 8 and 14 from one below, so an off-by-one compare is told apart from a wrong code decode. Full-store and single-entry bursts show that an overflowing character neither displaces stored data nor goes unreported. The timeout is probed one tick before and at the 768th tick, both after a push and after a pop, which distinguishes a timer that ignores host reads from one with a wrong limit.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rcq_entry_t;

  // threshold for each select code
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // keep 5..8 low bits of a character
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

endpackage

// File: rtl/rcq_store.sv
module rcq_store
  import rcq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_one,
  input  logic          flush,
  input  logic          wr_valid,
  input  rcq_entry_t    wr_entry,
  input  logic          rd_ready,
  output logic          rd_valid,
  output rcq_entry_t    rd_entry,
  output logic [CW-1:0] count,
  output logic          push,
  output logic          pop,
  output logic          ovr_q
);

  rcq_entry_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_entry = mem[rp];
  assign pop      = rd_valid && rd_ready && !flush;
  assign push     = wr_valid && !flush && (!full || pop);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovr_q <= 1'b0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      ovr_q <= wr_valid && full && !pop;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  ovr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !rd_ready && !flush) |=> (count == $past(count)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/rcq_timer.sv
module rcq_timer #(
  parameter int LIMIT = 768,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic active,
  output logic expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || !active)
      cnt <= '0;
    else if (tick && (cnt != TW'(LIMIT)))
      cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt == TW'(LIMIT));

  // R7
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);

endmodule

// File: rtl/rcq_ready.sv
module rcq_ready
  import rcq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          mode,
  input  logic          expired,
  output logic          avail,
  output logic          rdy_n
);

  logic [CW-1:0] lvl;
  logic          lat_q;
  logic          empty;

  always_comb begin
    int unsigned t;
    t   = trig_level(trig_sel);
    lvl = (t > DEPTH) ? CW'(DEPTH) : CW'(t);
  end

  assign empty = (count == '0);
  assign avail = fifo_en ? (count >= lvl) : !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= 1'b0;
    else if (empty)          lat_q <= 1'b0;
    else if (avail||expired) lat_q <= 1'b1;
  end

  assign rdy_n = mode ? (empty || !(lat_q || avail || expired)) : empty;

  // R9
  mode1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !rdy_n) ##1 (mode && !empty) |-> !rdy_n);

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rcq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int CHAR_BITS     = 12,
  parameter int CHAR_TIMES    = 4,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       cfg_fifo_en,
  input  logic [1:0] cfg_trig,
  input  logic       cfg_rdy_mode,
  input  logic [1:0] cfg_len,
  input  logic       rx_flush,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_perr,
  input  logic       in_ferr,
  input  logic       in_brk,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_perr,
  output logic       out_ferr,
  output logic       out_brk,
  output logic       data_ready,
  output logic       ovr_pulse,
  output logic       data_avail,
  output logic       char_timeout,
  output logic       rxrdy_n
);

  localparam int TO_LIMIT = CHAR_BITS * CHAR_TIMES * TICKS_PER_BIT;
  localparam int CW       = $clog2(DEPTH + 1);

  rcq_entry_t    wr_e, rd_e;
  logic [CW-1:0] count;
  logic          push, pop, en_q, flush_all, expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cfg_fifo_en;
  end

  assign flush_all = rx_flush || (en_q != cfg_fifo_en);

  always_comb begin
    wr_e.brk  = in_brk;
    wr_e.ferr = in_ferr;
    wr_e.perr = in_perr;
    wr_e.data = in_data & len_mask(cfg_len);
  end

  rcq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_one  (!cfg_fifo_en),
    .flush    (flush_all),
    .wr_valid (in_valid),
    .wr_entry (wr_e),
    .rd_ready (out_ready),
    .rd_valid (out_valid),
    .rd_entry (rd_e),
    .count    (count),
    .push     (push),
    .pop      (pop),
    .ovr_q    (ovr_pulse)
  );

  rcq_timer #(.LIMIT(TO_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .restart (push || pop || flush_all),
    .active  (cfg_fifo_en && (count != '0)),
    .expired (expired)
  );

  rcq_ready #(.DEPTH(DEPTH)) u_ready (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .fifo_en  (cfg_fifo_en),
    .trig_sel (cfg_trig),
    .mode     (cfg_rdy_mode),
    .expired  (expired),
    .avail    (data_avail),
    .rdy_n    (rxrdy_n)
  );

  assign out_data     = rd_e.data;
  assign out_perr     = rd_e.perr;
  assign out_ferr     = rd_e.ferr;
  assign out_brk      = rd_e.brk;
  assign data_ready   = out_valid;
  assign char_timeout = expired;

  // R7
  timeout_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_timeout |-> out_valid);

  // R8
  mode0_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdy_mode && out_valid) |-> !rxrdy_n);

  // R3
  len_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cfg_len == 2'b00) |=> ((count > 1) || out_data[7:5] == 3'b000));

endmodule

// File: tb/sim_rx_char_queue.sv
module sim_rx_char_queue;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b1;
  logic       cfg_fifo_en = 1'b1, cfg_rdy_mode = 1'b0, rx_flush = 1'b0;
  logic [1:0] cfg_trig = 2'b00, cfg_len = 2'b11;
  logic       in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b0;
  logic       out_valid, out_perr, out_ferr, out_brk;
  logic [7:0] out_data;
  logic       data_ready, ovr_pulse, data_avail, char_timeout, rxrdy_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [10:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_queue u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: offers one character, queues the expected item
  task automatic push(input logic [7:0] d, input logic [2:0] f);
    logic [7:0] m;
    bit room;
    m    = d & (8'hFF >> (2'd3 - cfg_len));
    room = exp_q.size() < (cfg_fifo_en ? 16 : 1);
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = d; {in_brk, in_ferr, in_perr} = f;
    @(posedge clk); #2;
    in_valid = 1'b0;
    if (room) exp_q.push_back({f, m});
    else chk("R5 overrun pulse", ovr_pulse, 1);
  endtask

  task automatic drain(input int n);
    @(posedge clk); #2 out_ready = 1'b1;
    repeat (n) @(posedge clk);
    #2 out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compares each popped character
  always @(negedge clk) begin
    if (rst_n && out_ready && out_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected character", 1, 0);
      else chk("R2 order/flags", {out_brk, out_ferr, out_perr, out_data}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 flags", {data_ready, data_avail, char_timeout, ovr_pulse}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 / R8: ordering with flags
    push(8'h41, 3'b000); push(8'h42, 3'b001); push(8'h43, 3'b110);
    chk("R2 data_ready", data_ready, 1);
    chk("R8 rxrdy_n low", rxrdy_n, 0);
    chk("R6 trig1 avail", data_avail, 1);
    drain(3);
    chk("R2 data_ready empty", data_ready, 0);
    chk("R8 rxrdy_n high", rxrdy_n, 1);

    // R3: right-justification
    cfg_len = 2'b00; push(8'hFF, 3'b000);
    cfg_len = 2'b01; push(8'hFF, 3'b000);
    cfg_len = 2'b10; push(8'hA5, 3'b000);
    cfg_len = 2'b11;
    drain(3);
    chk("R3 all drained", out_valid, 0);

    // R6: thresholds
    cfg_trig = 2'b01;
    for (int i = 0; i < 3; i++) push(8'(i), 3'b000);
    chk("R6 level 3 < 4", data_avail, 0);
    push(8'h03, 3'b000);
    chk("R6 level 4 >= 4", data_avail, 1);
    drain(1);
    chk("R6 drop below 4", data_avail, 0);
    cfg_trig = 2'b10;
    for (int i = 0; i < 4; i++) push(8'(16 + i), 3'b000);
    chk("R6 level 7 < 8", data_avail, 0);
    push(8'h20, 3'b000);
    chk("R6 level 8 >= 8", data_avail, 1);
    cfg_trig = 2'b11; #1;
    chk("R6 level 8 < 14", data_avail, 0);
    for (int i = 0; i < 5; i++) push(8'(32 + i), 3'b000);
    chk("R6 level 13 < 14", data_avail, 0);
    push(8'h30, 3'b000);
    chk("R6 level 14 >= 14", data_avail, 1);
    drain(14);
    cfg_trig = 2'b00;

    // R5 / R4: full store and overrun
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i), 3'(i));
    push(8'hEE, 3'b111);
    idle(1);
    chk("R5 pulse one cycle", ovr_pulse, 0);
    drain(16);
    chk("R4 sixteen held", out_valid, 0);

    // R4: single-entry mode
    cfg_fifo_en = 1'b0;
    idle(2);
    push(8'h5A, 3'b000);
    push(8'hA5, 3'b001);
    drain(1);
    chk("R4 single entry empty", out_valid, 0);
    push(8'h77, 3'b000);
    chk("R4 single holds one", out_valid, 1);
    cfg_fifo_en = 1'b1;
    idle(1);
    chk("R4 mode change empties", out_valid, 0);
    exp_q.delete();

    // R9: latched ready pin
    cfg_rdy_mode = 1'b1; cfg_trig = 2'b01;
    for (int i = 0; i < 3; i++) push(8'(8'h60 + i), 3'b000);
    chk("R9 below trigger", rxrdy_n, 1);
    push(8'h63, 3'b000);
    chk("R9 at trigger", rxrdy_n, 0);
    drain(1);
    chk("R9 avail dropped", data_avail, 0);
    chk("R9 stays low", rxrdy_n, 0);
    drain(3);
    chk("R9 high when empty", rxrdy_n, 1);

    // R7: timeout after a push, then after a pop
    push(8'h11, 3'b000);
    idle(767);
    chk("R7 before limit", char_timeout, 0);
    chk("R9 before timeout", rxrdy_n, 1);
    idle(1);
    chk("R7 at limit", char_timeout, 1);
    chk("R9 timeout low", rxrdy_n, 0);
    push(8'h12, 3'b000);
    chk("R7 push clears", char_timeout, 0);
    idle(300);
    drain(1);
    idle(767);
    chk("R7 pop restarts", char_timeout, 0);
    idle(1);
    chk("R7 limit after pop", char_timeout, 1);
    drain(1);
    chk("R7 empty no timeout", char_timeout, 0);
    cfg_rdy_mode = 1'b0; cfg_trig = 2'b00;

    // R10: flush with a simultaneous character
    push(8'h01, 3'b000); push(8'h02, 3'b000);
    @(posedge clk); #2;
    rx_flush = 1'b1; in_valid = 1'b1; in_data = 8'h03;
    @(posedge clk); #2;
    rx_flush = 1'b0; in_valid = 1'b0;
    exp_q.delete();
    chk("R10 flushed", out_valid, 0);
    chk("R10 data_ready", data_ready, 0);

    chk("R2 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule